// File: doc/BRIEF.md
# Overhead Channel Ping-Pong Insertion Buffer

This block holds general communication channel overhead words that a processor supplies for insertion into an outgoing frame. The processor writes through a single register window. Each write lands in the entry that a processor pointer selects, and the pointer then moves on by a programmable step of 0, 1, 2 or 3 entries. The processor may also reload the pointer so that the next write starts at any entry. The frame side reads entries in order through its own system pointer.

The 256 entries form two banks: entries 0 to 127 and entries 128 to 255. The two banks are used alternately. When the frame side finishes reading the last entry of a bank, a sticky ready flag is raised. An interrupt output, gated by an enable bit, tells the processor that this bank can now be refilled while the other bank is being read.

Three output channels each select one of two sources. A channel either carries the most recent buffer word, or it passes through the overhead received on that channel. A global transparent control forces every channel onto the received data. In SONET mode, every channel that is on the received data outputs zero instead.

Top module: `ovh_insert_buf`

## Requirements
- R1: After a synchronous reset, `cpu_ptr` is 0, `sys_ptr` is 0, `rdy_flag` is 0, `irq` is 0 and `rd_word` is 0.
- R2: A cycle with `cpu_wr_en`=1 stores `cpu_wr_data` (16 bits) in the entry that `cpu_ptr` selects at that edge. Each of the 256 entries holds its value until it is written again.
- R3: After each write, `cpu_ptr` advances modulo 256 by the amount that `cpu_step` gives. The code 2'b01 gives +1, 2'b10 gives +2 and 2'b11 gives +3. The code 2'b00 leaves the pointer unchanged.
- R4: When `cpu_ptr_load`=1, `cpu_ptr` takes the value of `cpu_ptr_val` at the next edge. The load takes precedence over the step. A write in the same cycle stores at the old pointer.
- R5: When `sys_rd_en`=1, `rd_word` shows the entry that `sys_ptr` selects, from the next cycle on. At the same edge, `sys_ptr` advances by 1 modulo 256. When no read occurs, `rd_word` holds its value.
- R6: `rdy_flag` becomes 1 on the edge of a system read at entry 127 or entry 255, which are the last entries of bank 0 and bank 1. A read at any other entry does not set it.
- R7: `rdy_flag` is sticky. A cycle with `rdy_clr`=1 clears it, unless that same cycle sets it, in which case the set wins.
- R8: `irq` is 1 exactly when `rdy_flag`=1 and `irq_en`=1.
- R9: Output channel i occupies `ovh_out[16*i+15:16*i]`. It carries received data when `force_transp`=1 or `ch_sel[i]`=1. Otherwise it carries `rd_word`.
- R10: When `sonet_mode`=1, every channel that carries received data outputs 0. When `sonet_mode`=0, such a channel outputs `rx_ovh[16*i+15:16*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Processor write strobe to the single data window |
| cpu_wr_data | input | 16 | Processor write data |
| cpu_step | input | 2 | Pointer step code: 00 hold, 01 +1, 10 +2, 11 +3 |
| cpu_ptr_load | input | 1 | Load `cpu_ptr` from `cpu_ptr_val` |
| cpu_ptr_val | input | 8 | Value to load into the processor pointer |
| cpu_ptr | output | 8 | Current processor pointer |
| sys_rd_en | input | 1 | Frame-side read strobe |
| sys_ptr | output | 8 | Current system pointer |
| rd_word | output | 16 | Word most recently read by the frame side |
| rdy_clr | input | 1 | Write-one-to-clear for the ready flag |
| irq_en | input | 1 | Interrupt enable (mask bit, 1 permits) |
| rdy_flag | output | 1 | Sticky bank-drained flag |
| irq | output | 1 | Interrupt output |
| ch_sel | input | 3 | Per-channel source: 1 selects received data |
| force_transp | input | 1 | Force all channels onto received data |
| sonet_mode | input | 1 | Zero the channels that carry received data |
| rx_ovh | input | 48 | Received overhead, 16 bits per channel |
| ovh_out | output | 48 | Overhead output, 16 bits per channel |

## Verification
Each step code writes to the buffer in its own pass. The passes start from loaded pointers and together interleave odd and even entries, overlap earlier data and wrap past entry 255. A wrong step or a wrong wrap shows up both in the pointer and in the data that is later read back in a full drain of both banks. The drain watches the ready flag on every read, which separates a set at entry 127 and at entry 255 from a set one entry early or late. Reads with a clear in the same cycle, and reads with the interrupt masked, separate the set-wins priority from the masking. A sweep over all channel selections, with the transparent control and SONET mode in each combination and distinct per-channel received values, tells apart swapped channels, a wrong selection polarity and the zeroing.

// File: rtl/ovh_buf_pkg.sv
package ovh_buf_pkg;

    parameter int unsigned DEPTH_DEF = 256;
    parameter int unsigned WIDTH_DEF = 16;
    parameter int unsigned NCH_DEF   = 3;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_ONE   = 2'b01,
        STEP_TWO   = 2'b10,
        STEP_THREE = 2'b11
    } step_code_e;

    typedef enum logic {
        SRC_BUFFER   = 1'b0,
        SRC_RECEIVED = 1'b1
    } ch_src_e;

    // Number of entries the processor pointer moves after a write.
    function automatic logic [1:0] step_amount(step_code_e code);
        case (code)
            STEP_ONE:   return 2'd1;
            STEP_TWO:   return 2'd2;
            STEP_THREE: return 2'd3;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ovh_wr_ptr.sv
module ovh_wr_ptr
    import ovh_buf_pkg::*;
#(
    parameter int unsigned DEPTH = DEPTH_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  step_code_e               step_code,
    input  logic                     load,
    input  logic [$clog2(DEPTH)-1:0] load_val,
    output logic [$clog2(DEPTH)-1:0] ptr
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = load_val;
        end else if (wr_en) begin
            ptr_d = ptr_q + PTR_W'(step_amount(step_code));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

    assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !load) |=> (ptr == $past(ptr) + PTR_W'(step_amount($past(step_code)))));

    assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !load) |=> (ptr == $past(ptr)));

    assert_load_wins_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (ptr == $past(load_val)));

endmodule

// File: rtl/ovh_store.sv
module ovh_store #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_q;

    assert_word_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/ovh_sys_side.sv
module ovh_sys_side #(
    parameter int unsigned DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  logic                     clr,
    output logic [$clog2(DEPTH)-1:0] ptr,
    output logic                     flag
);
    localparam int unsigned PTR_W     = $clog2(DEPTH);
    localparam int unsigned HALF      = DEPTH / 2;
    localparam logic [PTR_W-1:0] LAST0 = PTR_W'(HALF - 1);
    localparam logic [PTR_W-1:0] LAST1 = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic             flag_q;
    logic             bank_done;

    assign bank_done = rd_en && ((ptr_q == LAST0) || (ptr_q == LAST1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (rd_en) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if (bank_done) begin
                flag_q <= 1'b1;
            end else if (clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign ptr  = ptr_q;
    assign flag = flag_q;

    assert_sys_advance_R5: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (ptr == $past(ptr) + 1'b1));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (ptr == LAST0 || ptr == LAST1)) |=> flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !(rd_en && (ptr == LAST0 || ptr == LAST1))) |=> !flag);

    assert_flag_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(rd_en) && ($past(ptr) == LAST0 || $past(ptr) == LAST1)));

endmodule

// File: rtl/ovh_src_mux.sv
module ovh_src_mux
    import ovh_buf_pkg::*;
#(
    parameter int unsigned WIDTH = WIDTH_DEF,
    parameter int unsigned NCH   = NCH_DEF
) (
    input  logic [WIDTH-1:0]     buf_word,
    input  logic [NCH*WIDTH-1:0] rx_ovh,
    input  logic [NCH-1:0]       ch_sel,
    input  logic                 force_transp,
    input  logic                 sonet_mode,
    output logic [NCH*WIDTH-1:0] ovh_out
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        ch_src_e          src;
        logic [WIDTH-1:0] rx_word;

        assign src     = (force_transp || ch_sel[ch]) ? SRC_RECEIVED : SRC_BUFFER;
        assign rx_word = sonet_mode ? '0 : rx_ovh[ch*WIDTH +: WIDTH];

        always_comb begin
            case (src)
                SRC_RECEIVED: ovh_out[ch*WIDTH +: WIDTH] = rx_word;
                default:      ovh_out[ch*WIDTH +: WIDTH] = buf_word;
            endcase
        end
    end

endmodule

// File: rtl/ovh_insert_buf.sv
module ovh_insert_buf
    import ovh_buf_pkg::*;
#(
    parameter int unsigned DEPTH = DEPTH_DEF,
    parameter int unsigned WIDTH = WIDTH_DEF,
    parameter int unsigned NCH   = NCH_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_wr_en,
    input  logic [WIDTH-1:0]         cpu_wr_data,
    input  logic [1:0]               cpu_step,
    input  logic                     cpu_ptr_load,
    input  logic [$clog2(DEPTH)-1:0] cpu_ptr_val,
    output logic [$clog2(DEPTH)-1:0] cpu_ptr,
    input  logic                     sys_rd_en,
    output logic [$clog2(DEPTH)-1:0] sys_ptr,
    output logic [WIDTH-1:0]         rd_word,
    input  logic                     rdy_clr,
    input  logic                     irq_en,
    output logic                     rdy_flag,
    output logic                     irq,
    input  logic [NCH-1:0]           ch_sel,
    input  logic                     force_transp,
    input  logic                     sonet_mode,
    input  logic [NCH*WIDTH-1:0]     rx_ovh,
    output logic [NCH*WIDTH-1:0]     ovh_out
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    step_code_e       step_code;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [WIDTH-1:0] buf_word;
    logic             flag;

    assign step_code = step_code_e'(cpu_step);

    ovh_wr_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cpu_wr_en),
        .step_code (step_code),
        .load      (cpu_ptr_load),
        .load_val  (cpu_ptr_val),
        .ptr       (wr_ptr)
    );

    ovh_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cpu_wr_en),
        .wr_addr (wr_ptr),
        .wr_data (cpu_wr_data),
        .rd_en   (sys_rd_en),
        .rd_addr (rd_ptr),
        .rd_data (buf_word)
    );

    ovh_sys_side #(.DEPTH(DEPTH)) u_sys (
        .clk  (clk),
        .rst  (rst),
        .rd_en(sys_rd_en),
        .clr  (rdy_clr),
        .ptr  (rd_ptr),
        .flag (flag)
    );

    ovh_src_mux #(.WIDTH(WIDTH), .NCH(NCH)) u_mux (
        .buf_word    (buf_word),
        .rx_ovh      (rx_ovh),
        .ch_sel      (ch_sel),
        .force_transp(force_transp),
        .sonet_mode  (sonet_mode),
        .ovh_out     (ovh_out)
    );

    assign cpu_ptr  = wr_ptr;
    assign sys_ptr  = rd_ptr;
    assign rd_word  = buf_word;
    assign rdy_flag = flag;
    assign irq      = flag && irq_en;

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> rdy_flag);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    assert_sonet_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (force_transp && sonet_mode) |-> (ovh_out == '0));

    assert_all_buffer_R9: assert property (@(posedge clk) disable iff (rst)
        (!force_transp && ch_sel == '0) |-> (ovh_out == {NCH{rd_word}}));

endmodule

// File: tb/ovh_insert_buf_tb_top.sv
module ovh_insert_buf_tb_top;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_wr_en;
    logic [15:0] cpu_wr_data;
    logic [1:0]  cpu_step;
    logic        cpu_ptr_load;
    logic [7:0]  cpu_ptr_val;
    logic [7:0]  cpu_ptr;
    logic        sys_rd_en;
    logic [7:0]  sys_ptr;
    logic [15:0] rd_word;
    logic        rdy_clr;
    logic        irq_en;
    logic        rdy_flag;
    logic        irq;
    logic [2:0]  ch_sel;
    logic        force_transp;
    logic        sonet_mode;
    logic [47:0] rx_ovh;
    logic [47:0] ovh_out;

    always #(CLK_NS/2) clk = ~clk;

    ovh_insert_buf dut_i (
        .clk(clk), .rst(rst),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_step(cpu_step),
        .cpu_ptr_load(cpu_ptr_load), .cpu_ptr_val(cpu_ptr_val), .cpu_ptr(cpu_ptr),
        .sys_rd_en(sys_rd_en), .sys_ptr(sys_ptr), .rd_word(rd_word),
        .rdy_clr(rdy_clr), .irq_en(irq_en), .rdy_flag(rdy_flag), .irq(irq),
        .ch_sel(ch_sel), .force_transp(force_transp), .sonet_mode(sonet_mode),
        .rx_ovh(rx_ovh), .ovh_out(ovh_out)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;
    logic [15:0] mdl [256];
    int          mptr = 0;
    int          sptr = 0;
    logic        mflag = 0;
    logic [15:0] last_rd = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic int step_of(logic [1:0] c);
        return int'(c);
    endfunction

    // R2 R3: one processor write, with a pointer check.
    task automatic cpu_write(input logic [15:0] d, input logic [1:0] code);
        cpu_wr_en = 1; cpu_wr_data = d; cpu_step = code;
        @(negedge clk);
        cpu_wr_en = 0;
        mdl[mptr] = d;
        mptr = (mptr + step_of(code)) % 256;
        check(cpu_ptr == 8'(mptr), "R3 pointer step", 64'(cpu_ptr), 64'(mptr));
    endtask

    // R4: pointer load.
    task automatic cpu_load(input int v);
        cpu_ptr_load = 1; cpu_ptr_val = 8'(v);
        @(negedge clk);
        cpu_ptr_load = 0;
        mptr = v;
        check(cpu_ptr == 8'(v), "R4 pointer load", 64'(cpu_ptr), 64'(v));
    endtask

    // R5 R6 R7 R8: one frame-side read, optionally with a clear.
    task automatic sys_read(input bit clr);
        bit setc;
        sys_rd_en = 1; rdy_clr = clr;
        @(negedge clk);
        sys_rd_en = 0; rdy_clr = 0;
        setc = (sptr == 127) || (sptr == 255);
        last_rd = mdl[sptr];
        mflag = setc ? 1'b1 : (clr ? 1'b0 : mflag);
        check(rd_word == last_rd, "R2 R5 read data", 64'(rd_word), 64'(last_rd));
        sptr = (sptr + 1) % 256;
        if (sptr == 0 || sptr == 128 || sptr == 1)
            check(sys_ptr == 8'(sptr), "R5 system pointer", 64'(sys_ptr), 64'(sptr));
        check(rdy_flag == mflag, "R6 R7 ready flag", 64'(rdy_flag), 64'(mflag));
        check(irq == (mflag & irq_en), "R8 interrupt", 64'(irq), 64'(mflag & irq_en));
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] rx [3];
        logic [15:0] e;
        int          base;
        rst = 1; cpu_wr_en = 0; cpu_wr_data = 0; cpu_step = 0; cpu_ptr_load = 0;
        cpu_ptr_val = 0; sys_rd_en = 0; rdy_clr = 0; irq_en = 1; ch_sel = 0;
        force_transp = 0; sonet_mode = 0; rx_ovh = 0;
        for (int i = 0; i < 256; i++) mdl[i] = 16'hxxxx;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(cpu_ptr == 0, "R1 cpu_ptr", 64'(cpu_ptr), 0);
        check(sys_ptr == 0, "R1 sys_ptr", 64'(sys_ptr), 0);
        check(rdy_flag == 0, "R1 rdy_flag", 64'(rdy_flag), 0);
        check(irq == 0, "R1 irq", 64'(irq), 0);
        check(rd_word == 0, "R1 rd_word", 64'(rd_word), 0);

        // R3 step +1 over every entry of bank 0
        for (int i = 0; i < 128; i++) cpu_write(16'(i * 16'h9E37 + 16'h1234), 2'b01);
        // step +2 over even entries of bank 1, wrapping to 0
        cpu_load(128);
        for (int i = 0; i < 64; i++) cpu_write(16'(i * 16'h3B1D + 16'h0A0A), 2'b10);
        check(cpu_ptr == 0, "R3 wrap to 0", 64'(cpu_ptr), 0);
        // odd entries of bank 1
        cpu_load(129);
        for (int i = 0; i < 64; i++) cpu_write(16'(i * 16'h7F4B + 16'h5C00), 2'b10);
        // step +3 across the wrap, overwriting both banks
        cpu_load(200);
        for (int i = 0; i < 40; i++) cpu_write(16'(i * 16'h2D71 + 16'hC3C3), 2'b11);
        // R3 hold: code 00 leaves pointer, last write wins
        cpu_load(50);
        cpu_write(16'hAAAA, 2'b00);
        cpu_write(16'h5555, 2'b00);
        check(cpu_ptr == 50, "R3 hold", 64'(cpu_ptr), 50);
        // R4 load with a simultaneous write: write lands at old pointer
        cpu_wr_en = 1; cpu_wr_data = 16'hBEEF; cpu_step = 2'b11;
        cpu_ptr_load = 1; cpu_ptr_val = 8'd77;
        @(negedge clk);
        cpu_wr_en = 0; cpu_ptr_load = 0;
        mdl[50] = 16'hBEEF; mptr = 77;
        check(cpu_ptr == 77, "R4 load over step", 64'(cpu_ptr), 77);

        // Drain bank 0 with the interrupt enabled (R6, R8)
        irq_en = 1;
        for (int i = 0; i < 128; i++) sys_read(0);
        check(rdy_flag == 1, "R6 bank0 drained", 64'(rdy_flag), 1);
        // R7 sticky across further reads
        for (int i = 0; i < 40; i++) sys_read(0);
        // R7 clear
        rdy_clr = 1;
        @(negedge clk);
        rdy_clr = 0; mflag = 0;
        check(rdy_flag == 0, "R7 clear", 64'(rdy_flag), 0);
        // R8 masked drain of bank 1, clear and set together at entry 255
        irq_en = 0;
        while (sptr != 255) sys_read(0);
        sys_read(1);
        check(rdy_flag == 1, "R7 set wins over clear", 64'(rdy_flag), 1);
        check(irq == 0, "R8 masked", 64'(irq), 0);
        irq_en = 1;
        @(negedge clk);
        check(irq == 1, "R8 unmasked", 64'(irq), 1);
        rdy_clr = 1;
        @(negedge clk);
        rdy_clr = 0; mflag = 0;
        // second pass over bank 0 confirms stored data and no early set
        for (int i = 0; i < 10; i++) sys_read(0);

        // R9 R10 source mux sweep
        rx[0] = 16'h1111; rx[1] = 16'h2B2B; rx[2] = 16'hC3D4;
        rx_ovh = {rx[2], rx[1], rx[0]};
        for (int s = 0; s < 8; s++)
            for (int f = 0; f < 2; f++)
                for (int z = 0; z < 2; z++) begin
                    ch_sel = 3'(s); force_transp = f[0]; sonet_mode = z[0];
                    #1;
                    for (int c = 0; c < 3; c++) begin
                        base = c * 16;
                        if (f[0] || s[c]) e = z[0] ? 16'h0 : rx[c];
                        else e = last_rd;
                        check(ovh_out[base +: 16] == e, "R9 R10 channel source",
                              64'(ovh_out[base +: 16]), 64'(e));
                    end
                end
        @(negedge clk);
        summary();
    end

endmodule